// File: doc/BRIEF.md
# Integer Add-Subtract Unit with Stored Carry

This block is a parameterised integer adder/subtractor built around one ripple chain of one-bit full-adder slices. An operation code picks one of four carry-in policies. A plain add feeds 0 into the lowest slice. A plain subtract inverts B and feeds 1, so the chain computes A + ~B + 1. Add-with-carry and subtract-with-borrow take the lowest carry-in from a stored carry flag. Software can therefore chain word-sized operations into wider ones. The result bits are the same for signed and unsigned operands. Only the flags tell the two readings apart.

The carry flag is a register. It loads the carry-out of the current operation on a clock edge where the flag-write enable is high. Sum, carry-out, overflow and zero are combinational outputs.

A mode input selects one's-complement arithmetic. In that mode the chain runs with a carry-in of 0. Its top carry-out then goes through a second incrementer chain and is added back into the least significant bit. Because of this the adder never feeds its own output back into itself.

Top module: `addsub_unit`

## Requirements
- R1: With op_i = 2'b00 (add) and ones_i = 0, sum_o = (a_i + b_i) mod 2^WIDTH and carry_o is bit WIDTH of a_i + b_i; the stored flag has no effect.
- R2: With op_i = 2'b01 (add with carry) and ones_i = 0, {carry_o, sum_o} = a_i + b_i + cflag_o.
- R3: With op_i = 2'b10 (subtract) and ones_i = 0, {carry_o, sum_o} = a_i + ~b_i + 1, so carry_o is 1 exactly when a_i >= b_i as unsigned values.
- R4: With op_i = 2'b11 (subtract with borrow) and ones_i = 0, {carry_o, sum_o} = a_i + ~b_i + cflag_o, so a chain of such words subtracts wide numbers.
- R5: ovf_o is 1 exactly when a_i and the effective B operand (b_i for add ops, ~b_i for subtract ops) have the same top bit and the top bit of sum_o differs from it.
- R6: zero_o is 1 exactly when every bit of sum_o is 0. In one's-complement mode the all-ones pattern does not count as zero.
- R7: cflag_o takes the value of carry_o at a rising clk_i edge where flag_we_i is 1. It holds its value otherwise. It is 0 while rst_ni is low (asynchronous clear).
- R8: With ones_i = 1, the raw total r = a_i + effective B is formed with carry-in 0 for every op; op bit 0 and the stored flag are ignored. sum_o = (r mod 2^WIDTH) + r[WIDTH], and carry_o = r[WIDTH].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the carry flag |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| ones_i | input | 1 | One's-complement mode with end-around carry |
| flag_we_i | input | 1 | Load carry_o into the carry flag on the next rising edge |
| sum_o | output | WIDTH | Result |
| carry_o | output | 1 | Carry-out of the top slice (1 = no borrow on subtract) |
| ovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | Result is all zeros |
| cflag_o | output | 1 | Stored carry flag |

## Verification
The bench aims at the boundaries where each carry policy shows itself.
- An all-ones plus one add must wrap to zero with carry set. A wrong carry-in would leave a nonzero sum.
- A subtract of equal operands must give zero with carry 1. An inverted borrow sense would clear the carry.
- Signed-boundary cases such as 0x7F+1 and 0x80-1 must raise overflow. Without them, a flag computed from the wrong carry pair would go unnoticed.
- Two-word add and subtract chains with the flag-write enable held low between words show a flag that updates without the enable, or a borrow taken as a constant.
- One's-complement cases catch an end-around carry that is dropped or applied twice.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_ADDC = 2'b01,
    OP_SUB  = 2'b10,
    OP_SUBB = 2'b11
  } op_e;
endpackage

// File: rtl/addsub_slice.sv
module addsub_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/addsub_operand.sv
module addsub_operand #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_mux
    assign b_o[i] = inv_i ? ~b_i[i] : b_i[i];
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_msb_o,  // carry into top slice
  output logic             c_o
);
  logic [WIDTH:0] c;
  assign c[0] = c_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    addsub_slice u_slice (
      .a_i(a_i[i]),
      .b_i(b_i[i]),
      .c_i(c[i]),
      .s_o(s_o[i]),
      .c_o(c[i+1])
    );
  end

  assign c_msb_o = c[WIDTH-1];
  assign c_o     = c[WIDTH];
endmodule

// File: rtl/addsub_inc.sv
// End-around incrementer: adds en_i into the LSB via half-adder chain.
module addsub_inc #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] c;
  assign c[0] = en_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_ha
    assign y_o[i] = x_i[i] ^ c[i];
    if (i < WIDTH - 1) begin : g_c
      assign c[i+1] = x_i[i] & c[i];
    end
  end
endmodule

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  op_e  op_i,
  input  logic ones_i,
  input  logic cflag_i,
  output logic inv_o,
  output logic cin_o
);
  assign inv_o = (op_i == OP_SUB) || (op_i == OP_SUBB);

  always_comb begin
    if (ones_i) begin
      cin_o = 1'b0;
    end else begin
      unique case (op_i)
        OP_ADD:  cin_o = 1'b0;
        OP_ADDC: cin_o = cflag_i;
        OP_SUB:  cin_o = 1'b1;
        OP_SUBB: cin_o = cflag_i;
        default: cin_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             ones_i,
  input  logic             a_msb_i,
  input  logic             b_msb_i,
  input  logic             c_msb_i,
  input  logic             c_out_i,
  input  logic [WIDTH-1:0] res_i,
  output logic             ovf_o,
  output logic             zero_o
);
  logic sign_rule;
  // ones mode: result is adjusted after the chain, so the carry pair no longer applies
  assign sign_rule = (a_msb_i == b_msb_i) && (res_i[WIDTH-1] != a_msb_i);
  assign ovf_o     = ones_i ? sign_rule : (c_msb_i ^ c_out_i);
  assign zero_o    = ~|res_i;
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic             ones_i,
  input  logic             flag_we_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o,
  output logic             cflag_o
);
  localparam int unsigned MSB = WIDTH - 1;

  op_e              op;
  logic             inv, cin, c_msb, c_out;
  logic [WIDTH-1:0] b_eff, raw, res;

  assign op = op_e'(op_i);

  addsub_ctrl u_ctrl (
    .op_i   (op),
    .ones_i (ones_i),
    .cflag_i(cflag_o),
    .inv_o  (inv),
    .cin_o  (cin)
  );

  addsub_operand #(.WIDTH(WIDTH)) u_operand (
    .b_i  (b_i),
    .inv_i(inv),
    .b_o  (b_eff)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_chain (
    .a_i    (a_i),
    .b_i    (b_eff),
    .c_i    (cin),
    .s_o    (raw),
    .c_msb_o(c_msb),
    .c_o    (c_out)
  );

  addsub_inc #(.WIDTH(WIDTH)) u_eac (
    .x_i (raw),
    .en_i(ones_i & c_out),
    .y_o (res)
  );

  addsub_flags #(.WIDTH(WIDTH)) u_flags (
    .ones_i (ones_i),
    .a_msb_i(a_i[MSB]),
    .b_msb_i(b_eff[MSB]),
    .c_msb_i(c_msb),
    .c_out_i(c_out),
    .res_i  (res),
    .ovf_o  (ovf_o),
    .zero_o (zero_o)
  );

  assign sum_o   = res;
  assign carry_o = c_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cflag_o <= 1'b0;
    else if (flag_we_i) cflag_o <= c_out;
  end
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic             ones_i,
  input logic             flag_we_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             cflag_o
);
  localparam int unsigned MSB = WIDTH - 1;

  // R7
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> cflag_o == $past(carry_o));

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(cflag_o));

  // R1
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b00 && !ones_i) |-> {carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}));

  // R3
  sub_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10 && !ones_i) |-> carry_o == (a_i >= b_i));

  // R5
  add_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b00) |->
      ovf_o == ((a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB])));
endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .ones_i   (ones_i),
  .flag_we_i(flag_we_i),
  .sum_o    (sum_o),
  .carry_o  (carry_o),
  .ovf_o    (ovf_o),
  .cflag_o  (cflag_o)
);

// File: tb/addsub_unit_test.sv
`timescale 1ns/1ps
module addsub_unit_test;
  localparam int W = 8;

  logic         clk = 0, rst_ni = 0;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0]   op = 2'b00;
  logic         ones = 0, we = 0;
  logic [W-1:0] sum;
  logic         carry, ovf, zero, cflag;

  int total = 0, bad = 0;
  logic model_c = 0;

  typedef struct {
    logic [W-1:0] sum;
    logic         carry, ovf, zero, cflag;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  addsub_unit #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .op_i(op),
    .ones_i(ones), .flag_we_i(we), .sum_o(sum), .carry_o(carry),
    .ovf_o(ovf), .zero_o(zero), .cflag_o(cflag)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] ex);
    total++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, ex);
    end
  endtask

  // driver: drive at negedge, push model result
  task automatic drive(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic om, input logic w, input string tag);
    exp_t e;
    logic [W-1:0] bb;
    logic         ci;
    logic [W:0]   full;
    @(negedge clk);
    a = x; b = y; op = o; ones = om; we = w;
    bb = o[1] ? ~y : y;
    if (om) ci = 1'b0;
    else    ci = (o == 2'b00) ? 1'b0 : (o == 2'b10) ? 1'b1 : model_c;
    full = {1'b0, x} + {1'b0, bb} + {{W{1'b0}}, ci};
    e.carry = full[W];
    e.sum   = om ? full[W-1:0] + {{(W-1){1'b0}}, full[W]} : full[W-1:0];
    e.ovf   = (x[W-1] == bb[W-1]) && (e.sum[W-1] != x[W-1]);
    e.zero  = (e.sum == '0);
    e.cflag = model_c;
    e.tag   = tag;
    q.push_back(e);
    if (w) model_c = e.carry;
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " sum"},   sum,           e.sum);
      check({e.tag, " carry"}, W'(carry),     W'(e.carry));
      check({"R5 ", e.tag, " ovf"},  W'(ovf),  W'(e.ovf));
      check({"R6 ", e.tag, " zero"}, W'(zero), W'(e.zero));
      check({"R7 ", e.tag, " cflag"}, W'(cflag), W'(e.cflag));
    end
  end

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check("R7 reset cflag", W'(cflag), '0);
    repeat (2) @(negedge clk);
    rst_ni = 1;

    drive(2'b00, 8'hFF, 8'h01, 0, 1, "R1 wrap");
    drive(2'b00, 8'h7F, 8'h01, 0, 0, "R1 ovf");
    drive(2'b01, 8'h10, 8'h20, 0, 0, "R2 flag1");    // flag=1 from wrap
    drive(2'b10, 8'h05, 8'h03, 0, 0, "R3 5-3");
    drive(2'b10, 8'h03, 8'h05, 0, 0, "R3 3-5");
    drive(2'b10, 8'h42, 8'h42, 0, 0, "R3 equal");
    drive(2'b10, 8'h80, 8'h01, 0, 0, "R3 ovf");
    // two-word add 0x01FF + 0x0001
    drive(2'b00, 8'hFF, 8'h01, 0, 1, "R1 lo word");
    drive(2'b01, 8'h01, 8'h00, 0, 0, "R2 hi word");
    drive(2'b01, 8'h01, 8'h00, 0, 1, "R2 flag held");
    // two-word sub 0x0200 - 0x0001
    drive(2'b10, 8'h00, 8'h01, 0, 1, "R3 lo word");
    drive(2'b11, 8'h02, 8'h00, 0, 1, "R4 hi word");
    drive(2'b11, 8'h00, 8'h00, 0, 0, "R4 no borrow");
    // ones complement
    drive(2'b00, 8'hFE, 8'h03, 1, 0, "R8 eac add");
    drive(2'b10, 8'h05, 8'h03, 1, 0, "R8 eac sub");
    drive(2'b10, 8'h05, 8'h05, 1, 0, "R8 neg zero");
    drive(2'b01, 8'h10, 8'h01, 1, 1, "R8 ignore flag");
    drive(2'b11, 8'h10, 8'h01, 1, 0, "R8 subb ign");
    for (int i = 0; i < 300; i++)
      drive(2'($urandom), 8'($urandom), 8'($urandom), 1'($urandom_range(0, 3) == 0),
            1'($urandom), "R1 R2 R3 R4 R8 rand");
    repeat (3) @(negedge clk);

    // async reset clears a set flag
    drive(2'b00, 8'h80, 8'h80, 0, 1, "R7 set");
    @(negedge clk);
    check("R7 flag set", W'(cflag), W'(1'b1));
    #1 rst_ni = 0;
    #1 check("R7 async clear", W'(cflag), '0);
    model_c = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule